// File: doc/BRIEF.md
# Dual-Port Doorbell Mailbox

This block lets two processors signal each other through single-bit doorbells. Each processor reaches the block through its own APB slave port: port A serves the local side and port B serves the remote side. There are three independent links, ordered as low priority, high priority and secure. Each link holds one 32-bit doorbell word for each direction, so the block holds six words in total. A sender rings a doorbell by writing a one to the set register of its transmit group. The receiver sees the bit in its receive group and gets a level interrupt. It then clears the bit by writing a one to the clear register of its receive group.

Each link has one interrupt per side. That interrupt is the OR of all 32 bits of the receive word for that side and link. It stays high until the receiver has cleared every bit. A sender learns that a doorbell has been consumed by polling its transmit status until the bit returns to zero. Both APB ports complete every transfer in one access cycle, because PREADY is tied high. There is no data stream, so there is no valid/ready flow control and no back-pressure. Every pin outside the two APB ports is a plain level signal.

Top module: `doorbell_mailbox`

## Requirements
- R1: Each port decodes a 12-bit byte address. The receive groups of link 0, link 1 and link 2 start at 0x000, 0x020 and 0x200. Each link's transmit group starts 0x100 above its receive group. Within a group, the status word is at +0x0, the set register is at +0x8 and the clear register is at +0x10.
- R2: A write to a set register ORs the ones of PWDATA into the targeted word. Zero bits leave the word unchanged. With no write on either port, no word and no interrupt changes.
- R3: A write to a clear register clears exactly the bits written as one. All other bits keep their value.
- R4: One side's transmit word of a link is the other side's receive word of the same link. A value set through port A's transmit group reads back from port A's transmit status and from port B's receive status, and the same holds with the ports swapped.
- R5: Output a_irq[l] is the OR of port A's receive word of link l, and b_irq[l] is the same for port B. Each interrupt rises in the clock cycle after the set write and stays high until the last bit is cleared.
- R6: Set and clear registers read as zero. A write to a status offset changes nothing.
- R7: An unmapped address reads zero with PSLVERR low, and a write to it changes nothing. PREADY is always high.
- R8: If a set from one port and a clear from the other port hit the same bit in the same cycle, the bit ends up set. Bits that are only cleared still clear.
- R9: An access to any link 2 register with PPROT[1]=1 reads zero, has no effect when it is a write, and drives PSLVERR high during the access phase. The same access with PPROT[1]=0 works normally.
- R10: Reset clears all six words, so every status reads zero and every interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both APB ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_psel | input | 1 | Port A select |
| a_penable | input | 1 | Port A access phase |
| a_pwrite | input | 1 | Port A write strobe |
| a_paddr | input | 12 | Port A byte address |
| a_pwdata | input | 32 | Port A write data |
| a_pprot | input | 3 | Port A protection; bit 1 high means non-secure |
| a_prdata | output | 32 | Port A read data |
| a_pready | output | 1 | Port A ready, always high |
| a_pslverr | output | 1 | Port A error, for blocked secure accesses |
| b_psel | input | 1 | Port B select |
| b_penable | input | 1 | Port B access phase |
| b_pwrite | input | 1 | Port B write strobe |
| b_paddr | input | 12 | Port B byte address |
| b_pwdata | input | 32 | Port B write data |
| b_pprot | input | 3 | Port B protection; bit 1 high means non-secure |
| b_prdata | output | 32 | Port B read data |
| b_pready | output | 1 | Port B ready, always high |
| b_pslverr | output | 1 | Port B error, for blocked secure accesses |
| a_irq | output | 3 | Port A receive interrupts, one per link |
| b_irq | output | 3 | Port B receive interrupts, one per link |

## Verification
A set write from one port and a clear write from the other port can reach the same doorbell word in the same clock edge. This is the case where a sender rings again while the receiver is still acknowledging. The bench provokes it by running an access phase on both ports together: one port sets a pattern in its transmit group, and the other clears all ones in its receive group over a word that already holds other bits. The bench judges the result by reading the word back from both sides and comparing it with its model, in which set wins and clear-only bits drop. It also checks that the receiver's interrupt is still high.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int NUM_LINKS   = 3;
  localparam int SECURE_LINK = 2;
  localparam int TX_SHIFT    = 'h100;
  localparam int OFS_SET     = 'h8;
  localparam int OFS_CLR     = 'h10;

  typedef enum logic [1:0] {OP_NONE, OP_STAT, OP_SET, OP_CLR} reg_op_e;

  typedef struct packed {
    logic    hit;
    logic    [1:0] link;
    logic    is_tx;
    reg_op_e op;
  } dec_t;

  function automatic int unsigned link_base(input int l);
    case (l)
      0:       return 'h000;
      1:       return 'h020;
      default: return 'h200;
    endcase
  endfunction
endpackage

// File: rtl/dbm_decode.sv
module dbm_decode
  import dbm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] paddr,
  output dec_t              dec
);
  logic [31:0] addr32;

  always_comb begin
    addr32 = 32'(paddr);
    dec    = '0;
    for (int l = 0; l < NUM_LINKS; l++) begin
      for (int t = 0; t < 2; t++) begin
        int unsigned grp;
        grp = link_base(l) + (t == 1 ? TX_SHIFT : 0);
        if (addr32 == grp) begin
          dec = '{hit: 1'b1, link: 2'(l), is_tx: t[0], op: OP_STAT};
        end else if (addr32 == grp + OFS_SET) begin
          dec = '{hit: 1'b1, link: 2'(l), is_tx: t[0], op: OP_SET};
        end else if (addr32 == grp + OFS_CLR) begin
          dec = '{hit: 1'b1, link: 2'(l), is_tx: t[0], op: OP_CLR};
        end
      end
    end
  end
endmodule

// File: rtl/dbm_port.sv
module dbm_port
  import dbm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 12,
  parameter bit SIDE   = 1'b0,
  localparam int NW    = 2 * NUM_LINKS
) (
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [WORD_W-1:0]          pwdata,
  input  logic [2:0]                 pprot,
  input  logic [NW-1:0][WORD_W-1:0]  words,
  output logic [WORD_W-1:0]          prdata,
  output logic                       pslverr,
  output logic [NW-1:0][WORD_W-1:0]  set_mask,
  output logic [NW-1:0][WORD_W-1:0]  clr_mask
);
  dec_t dec;
  logic access;
  logic blocked;
  logic dir;
  int   widx;

  dbm_decode #(.ADDR_W(ADDR_W)) u_dec (.paddr(paddr), .dec(dec));

  assign access  = psel && penable;
  assign blocked = dec.hit && (int'(dec.link) == SECURE_LINK) && pprot[1];
  // direction 0 carries A->B traffic, direction 1 carries B->A traffic
  assign dir     = ~(dec.is_tx ^ SIDE);
  assign widx    = int'(dir) * NUM_LINKS + int'(dec.link);
  assign pslverr = access && blocked;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    prdata   = '0;
    if (access && dec.hit && !blocked) begin
      if (pwrite) begin
        if (dec.op == OP_SET) set_mask[widx] = pwdata;
        if (dec.op == OP_CLR) clr_mask[widx] = pwdata;
      end else if (dec.op == OP_STAT) begin
        prdata = words[widx];
      end
    end
  end
endmodule

// File: rtl/dbm_word.sv
module dbm_word #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_a,
  input  logic [WORD_W-1:0] set_b,
  input  logic [WORD_W-1:0] clr_a,
  input  logic [WORD_W-1:0] clr_b,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~(clr_a | clr_b)) | set_a | set_b;
  end
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import dbm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_psel,
  input  logic              a_penable,
  input  logic              a_pwrite,
  input  logic [ADDR_W-1:0] a_paddr,
  input  logic [WORD_W-1:0] a_pwdata,
  input  logic [2:0]        a_pprot,
  output logic [WORD_W-1:0] a_prdata,
  output logic              a_pready,
  output logic              a_pslverr,
  input  logic              b_psel,
  input  logic              b_penable,
  input  logic              b_pwrite,
  input  logic [ADDR_W-1:0] b_paddr,
  input  logic [WORD_W-1:0] b_pwdata,
  input  logic [2:0]        b_pprot,
  output logic [WORD_W-1:0] b_prdata,
  output logic              b_pready,
  output logic              b_pslverr,
  output logic [NUM_LINKS-1:0] a_irq,
  output logic [NUM_LINKS-1:0] b_irq
);
  localparam int NW = 2 * NUM_LINKS;

  logic [NW-1:0][WORD_W-1:0] words;
  logic [NW-1:0][WORD_W-1:0] set_a, clr_a, set_b, clr_b;

  dbm_port #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SIDE(1'b0)) u_port_a (
    .psel(a_psel), .penable(a_penable), .pwrite(a_pwrite), .paddr(a_paddr),
    .pwdata(a_pwdata), .pprot(a_pprot), .words(words), .prdata(a_prdata),
    .pslverr(a_pslverr), .set_mask(set_a), .clr_mask(clr_a)
  );

  dbm_port #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SIDE(1'b1)) u_port_b (
    .psel(b_psel), .penable(b_penable), .pwrite(b_pwrite), .paddr(b_paddr),
    .pwdata(b_pwdata), .pprot(b_pprot), .words(words), .prdata(b_prdata),
    .pslverr(b_pslverr), .set_mask(set_b), .clr_mask(clr_b)
  );

  for (genvar w = 0; w < NW; w++) begin : g_word
    dbm_word #(.WORD_W(WORD_W)) u_word (
      .clk(clk), .rst_n(rst_n),
      .set_a(set_a[w]), .set_b(set_b[w]),
      .clr_a(clr_a[w]), .clr_b(clr_b[w]),
      .q(words[w])
    );
  end

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_irq
    assign b_irq[l] = |words[l];
    assign a_irq[l] = |words[NUM_LINKS + l];
  end

  assign a_pready = 1'b1;
  assign b_pready = 1'b1;
endmodule

// File: rtl/dbm_mailbox_chk.sv
module dbm_mailbox_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_psel,
  input logic              a_penable,
  input logic              a_pwrite,
  input logic [ADDR_W-1:0] a_paddr,
  input logic [WORD_W-1:0] a_pwdata,
  input logic [2:0]        a_pprot,
  input logic [WORD_W-1:0] a_prdata,
  input logic              a_pready,
  input logic              a_pslverr,
  input logic              b_psel,
  input logic              b_penable,
  input logic              b_pwrite,
  input logic [ADDR_W-1:0] b_paddr,
  input logic [WORD_W-1:0] b_pwdata,
  input logic [2:0]        b_pprot,
  input logic [WORD_W-1:0] b_prdata,
  input logic              b_pready,
  input logic              b_pslverr,
  input logic [2:0]        a_irq,
  input logic [2:0]        b_irq
);
  logic a_acc, b_acc, b_set_l0, a_clr_l0, a_sec;

  assign a_acc    = a_psel && a_penable;
  assign b_acc    = b_psel && b_penable;
  assign b_set_l0 = b_acc && b_pwrite && (b_paddr == ADDR_W'('h108)) && (b_pwdata != '0);
  assign a_clr_l0 = a_acc && a_pwrite && (a_paddr == ADDR_W'('h010)) && (&a_pwdata);
  assign a_sec    = (a_paddr == ADDR_W'('h200)) || (a_paddr == ADDR_W'('h208)) ||
                    (a_paddr == ADDR_W'('h210)) || (a_paddr == ADDR_W'('h300)) ||
                    (a_paddr == ADDR_W'('h308)) || (a_paddr == ADDR_W'('h310));

  assert_set_raises_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    b_set_l0 |=> a_irq[0]);

  assert_clear_drops_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_clr_l0 && !(b_acc && b_pwrite)) |=> !a_irq[0]);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_clr_l0 && b_set_l0) |=> a_irq[0]);

  assert_secure_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_acc && a_pprot[1] && a_sec) |-> (a_pslverr && a_prdata == '0));

  assert_unmapped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_acc && a_paddr == ADDR_W'('h004)) |-> (!a_pslverr && a_prdata == '0));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !((a_acc && a_pwrite) || (b_acc && b_pwrite)) |=> ($stable(a_irq) && $stable(b_irq)));
endmodule

bind doorbell_mailbox dbm_mailbox_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_doorbell_mailbox.sv
module tb_doorbell_mailbox;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_psel = 0, a_penable = 0, a_pwrite = 0;
  logic [11:0] a_paddr = '0;
  logic [31:0] a_pwdata = '0;
  logic [2:0]  a_pprot = '0;
  logic [31:0] a_prdata;
  logic a_pready, a_pslverr;
  logic b_psel = 0, b_penable = 0, b_pwrite = 0;
  logic [11:0] b_paddr = '0;
  logic [31:0] b_pwdata = '0;
  logic [2:0]  b_pprot = '0;
  logic [31:0] b_prdata;
  logic b_pready, b_pslverr;
  logic [2:0] a_irq, b_irq;

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] mdl [6];

  always #2 clk = ~clk;

  doorbell_mailbox dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] grp(input int link, input bit tx);
    int b;
    b = (link == 0) ? 'h000 : (link == 1) ? 'h020 : 'h200;
    return 12'(b + (tx ? 'h100 : 0));
  endfunction

  // word index: direction 0 = A->B, 1 = B->A
  function automatic int widx(input bit side, input bit tx, input int link);
    return ((tx == side) ? 1 : 0) * 3 + link;
  endfunction

  function automatic logic [2:0] exp_irq(input bit side);
    logic [2:0] r;
    for (int l = 0; l < 3; l++) r[l] = side ? (mdl[l] != 0) : (mdl[3 + l] != 0);
    return r;
  endfunction

  task automatic acc(input bit side, input bit wr, input logic [11:0] addr,
                     input logic [31:0] wd, input logic [2:0] prot,
                     output logic [31:0] rd, output logic err);
    @(negedge clk);
    if (!side) begin a_psel = 1; a_pwrite = wr; a_paddr = addr; a_pwdata = wd; a_pprot = prot; end
    else       begin b_psel = 1; b_pwrite = wr; b_paddr = addr; b_pwdata = wd; b_pprot = prot; end
    @(negedge clk);
    if (!side) a_penable = 1; else b_penable = 1;
    #1;
    rd  = side ? b_prdata : a_prdata;
    err = side ? b_pslverr : a_pslverr;
    @(posedge clk); #0.5;
    a_psel = 0; a_penable = 0; b_psel = 0; b_penable = 0;
  endtask

  task automatic dual_wr(input logic [11:0] aa, input logic [31:0] ad,
                         input logic [11:0] ba, input logic [31:0] bd);
    @(negedge clk);
    a_psel = 1; a_pwrite = 1; a_paddr = aa; a_pwdata = ad; a_pprot = 0;
    b_psel = 1; b_pwrite = 1; b_paddr = ba; b_pwdata = bd; b_pprot = 0;
    @(negedge clk);
    a_penable = 1; b_penable = 1;
    @(posedge clk); #0.5;
    a_psel = 0; a_penable = 0; b_psel = 0; b_penable = 0;
  endtask

  task automatic rd_chk(input bit side, input logic [11:0] addr, input logic [2:0] prot,
                        input logic [31:0] exp, input logic exp_err, input string req);
    logic [31:0] d; logic e;
    acc(side, 1'b0, addr, '0, prot, d, e);
    check(req, d, exp);
    check(req, {31'b0, e}, {31'b0, exp_err});
  endtask

  task automatic wr(input bit side, input logic [11:0] addr, input logic [31:0] d,
                    input logic [2:0] prot);
    logic [31:0] x; logic e;
    acc(side, 1'b1, addr, d, prot, x, e);
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h0000_0001; pats[1] = 32'h8000_0001;
    pats[2] = 32'hA5A5_5A5A; pats[3] = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10: reset state
    check("R10 a_irq", {29'b0, a_irq}, 32'h0);
    check("R10 b_irq", {29'b0, b_irq}, 32'h0);
    for (int l = 0; l < 3; l++)
      for (int t = 0; t < 2; t++)
        rd_chk(1'b0, grp(l, t[0]), 3'b000, 32'h0, 1'b0, "R10 status");
    check("R7 pready", {30'b0, a_pready, b_pready}, 32'h3);

    // R1 R2 R3 R4 R5: sweep sides, links, patterns
    for (int s = 0; s < 2; s++) begin
      for (int l = 0; l < 3; l++) begin
        for (int p = 0; p < 4; p++) begin
          bit snd; bit rcv; int w;
          snd = s[0]; rcv = ~s[0]; w = widx(snd, 1'b1, l);
          wr(snd, grp(l, 1) + 12'h8, pats[p], 3'b000);
          mdl[w] |= pats[p];
          rd_chk(snd, grp(l, 1), 3'b000, mdl[w], 1'b0, "R2 R4 sender tx status");
          rd_chk(rcv, grp(l, 0), 3'b000, mdl[w], 1'b0, "R1 R4 receiver rx status");
          check("R5 irq A", {29'b0, a_irq}, {29'b0, exp_irq(1'b0)});
          check("R5 irq B", {29'b0, b_irq}, {29'b0, exp_irq(1'b1)});
          wr(rcv, grp(l, 0) + 12'h10, pats[p] & 32'h0000_FFFF, 3'b000);
          mdl[w] &= ~(pats[p] & 32'h0000_FFFF);
          rd_chk(snd, grp(l, 1), 3'b000, mdl[w], 1'b0, "R3 partial clear");
          check("R5 irq held", {29'b0, a_irq, b_irq}, {29'b0, exp_irq(1'b0), exp_irq(1'b1)} & 32'h3F);
          wr(rcv, grp(l, 0) + 12'h10, 32'hFFFF_FFFF, 3'b000);
          mdl[w] = '0;
          rd_chk(snd, grp(l, 1), 3'b000, 32'h0, 1'b0, "R3 consumed");
          check("R5 irq low", {26'b0, a_irq, b_irq}, 32'h0);
        end
      end
    end

    // R2: zero bits keep status
    wr(1'b0, 12'h128, 32'h0000_0F00, 3'b000); mdl[1] = 32'h0000_0F00;
    wr(1'b0, 12'h128, 32'h0000_0000, 3'b000);
    rd_chk(1'b1, 12'h020, 3'b000, 32'h0000_0F00, 1'b0, "R2 zero write");

    // R6: set/clear read zero, status write ignored
    rd_chk(1'b0, 12'h128, 3'b000, 32'h0, 1'b0, "R6 set reads zero");
    rd_chk(1'b1, 12'h030, 3'b000, 32'h0, 1'b0, "R6 clear reads zero");
    wr(1'b0, 12'h120, 32'hFFFF_FFFF, 3'b000);
    wr(1'b1, 12'h020, 32'h0000_0000, 3'b000);
    rd_chk(1'b0, 12'h120, 3'b000, 32'h0000_0F00, 1'b0, "R6 status write ignored");

    // R8: set from A tx and clear from B rx on link 1 in the same cycle
    dual_wr(12'h128, 32'h0000_00FF, 12'h030, 32'hFFFF_FFFF);
    mdl[1] = 32'h0000_00FF;
    rd_chk(1'b1, 12'h020, 3'b000, 32'h0000_00FF, 1'b0, "R8 set wins");
    check("R8 irq", {31'b0, b_irq[1]}, 32'h1);
    wr(1'b1, 12'h030, 32'hFFFF_FFFF, 3'b000); mdl[1] = '0;

    // R7: unmapped addresses
    begin
      logic [11:0] um [6];
      um[0] = 12'h004; um[1] = 12'h00C; um[2] = 12'h018;
      um[3] = 12'h040; um[4] = 12'h400; um[5] = 12'hFFC;
      for (int i = 0; i < 6; i++) begin
        wr(1'b0, um[i], 32'hFFFF_FFFF, 3'b010);
        rd_chk(1'b1, um[i], 3'b000, 32'h0, 1'b0, "R7 unmapped");
      end
      check("R7 no side effect", {26'b0, a_irq, b_irq}, 32'h0);
    end

    // R9: non-secure access to link 2
    wr(1'b0, 12'h308, 32'h0000_0003, 3'b010);
    rd_chk(1'b1, 12'h200, 3'b000, 32'h0, 1'b0, "R9 ns write blocked");
    check("R9 irq stays low", {31'b0, b_irq[2]}, 32'h0);
    wr(1'b0, 12'h308, 32'h0000_0003, 3'b000); mdl[2] = 32'h3;
    rd_chk(1'b1, 12'h200, 3'b010, 32'h0, 1'b1, "R9 ns read blocked");
    rd_chk(1'b1, 12'h200, 3'b000, 32'h3, 1'b0, "R9 secure read");
    wr(1'b1, 12'h210, 32'hFFFF_FFFF, 3'b010);
    rd_chk(1'b0, 12'h300, 3'b000, 32'h3, 1'b0, "R9 ns clear blocked");
    wr(1'b1, 12'h210, 32'hFFFF_FFFF, 3'b000); mdl[2] = '0;
    rd_chk(1'b0, 12'h300, 3'b000, 32'h0, 1'b0, "R9 secure clear");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #600000;
    n_checks++; n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule